// File: doc/BRIEF.md
# Block Address Translation Matcher

This block maps an effective address onto a real page address through a small set of block-translation entries. Each entry has an upper word and a lower word. The upper word carries a block base, a block-length field and two valid bits, one for each privilege level. The lower word carries the real block base and a two-bit protection code. Instruction fetches use one bank of entries and every other access uses a second bank, which has the same layout.

A lookup takes an effective address, a fetch flag and a user-mode flag. All entries of the selected bank are compared in parallel, and the entry with the lowest index that matches supplies the result. The result is registered: a hit flag, the real page address, and read, write and execute rights. A single write port loads either word of any entry in either bank. Faults and page-table walks are handled elsewhere.

Top module: `blk_xlate_match`

## Requirements
- R1: After the synchronous reset, every output is zero and every entry word is zero, so each lookup misses until entries are written.
- R2: An entry can take part in a lookup only if the valid bit for the current privilege is set in its upper word. Bit 1 serves supervisor lookups (`lk_user`=0) and bit 0 serves user lookups (`lk_user`=1).
- R3: The upper word holds the block base in bits 31:17 and the block length in bits 12:2. The compare mask is 0xFFFE0000 with bits 27:17 cleared wherever the length field, shifted left by 15, has ones. An entry matches when the effective address ANDed with the mask equals the upper word's bits 31:17 (lower bits zero). A stored base with ones in masked-out positions therefore never matches.
- R4: On a hit, the real page is formed from the lower word's bits under the mask and the effective address's bits outside the mask. Bits 11:0 of the result are zero.
- R5: When several entries match, the one with the lowest index wins.
- R6: Bits 1:0 of the lower word give the rights. Code 0 gives no rights, code 2 gives read, write and execute, and codes 1 and 3 give read and execute.
- R7: A lookup with `lk_fetch`=1 searches only the instruction bank. A lookup with `lk_fetch`=0 searches only the data bank. A write with `wr_fetch_side`=1 goes to the instruction bank, and `wr_lower` selects the lower word (1) or the upper word (0).
- R8: On a miss, the hit flag, the real page and all three rights are zero.
- R9: Lookup results appear on the outputs at the first rising edge after the inputs are applied, and hold until that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Entry write strobe |
| wr_fetch_side | input | 1 | 1 selects the instruction bank for the write |
| wr_lower | input | 1 | 1 writes the lower word, 0 writes the upper word |
| wr_idx | input | IDX_W (2) | Entry index for the write |
| wr_data | input | ADDR_W (32) | Word to write |
| lk_ea | input | ADDR_W (32) | Effective address to translate |
| lk_fetch | input | 1 | 1 for an instruction fetch |
| lk_user | input | 1 | 1 for user mode, 0 for supervisor |
| hit | output | 1 | Registered match flag |
| real_page | output | ADDR_W (32) | Registered real page address |
| can_read | output | 1 | Registered read right |
| can_write | output | 1 | Registered write right |
| can_exec | output | 1 | Registered execute right |

## Verification
The hardest case to reach from the ports is contention between entries: two entries with different block lengths that both cover the same address, with one of them later made invalid for the current privilege only. The stimulus sets up such overlaps on purpose. It then sweeps thousands of addresses drawn from a shift register and biased toward the stored block bases, across both banks and both privilege levels. Block lengths range from the smallest block to the full 256 MB span, and one entry has a base with ones in masked-out positions, so that entry can never match.

// File: rtl/blk_xlate_pkg.sv
package blk_xlate_pkg;

  typedef struct packed {
    logic r;
    logic w;
    logic x;
  } blk_perm_t;

  // Two-bit protection code to access rights.
  function automatic blk_perm_t decode_prot(input logic [1:0] code);
    blk_perm_t p;
    unique case (code)
      2'd0:    p = '{r: 1'b0, w: 1'b0, x: 1'b0};
      2'd2:    p = '{r: 1'b1, w: 1'b1, x: 1'b1};
      default: p = '{r: 1'b1, w: 1'b0, x: 1'b1};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/blk_entry_cmp.sv
module blk_entry_cmp
  import blk_xlate_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BASE_LSB  = 17,
  parameter int LEN_LSB   = 2,
  parameter int LEN_W     = 11,
  parameter int PAGE_BITS = 12
) (
  input  logic [ADDR_W-1:0] upper,
  input  logic [ADDR_W-1:0] lower,
  input  logic [ADDR_W-1:0] ea,
  input  logic              is_user,
  output logic              match,
  output logic [ADDR_W-1:0] page,
  output blk_perm_t         perm
);

  localparam logic [ADDR_W-1:0] BASE_MASK = {{(ADDR_W-BASE_LSB){1'b1}}, {BASE_LSB{1'b0}}};
  localparam logic [ADDR_W-1:0] PAGE_MASK = {{(ADDR_W-PAGE_BITS){1'b1}}, {PAGE_BITS{1'b0}}};

  logic              usable;
  logic [ADDR_W-1:0] len_spread;
  logic [ADDR_W-1:0] cmp_mask;

  always_comb begin
    usable     = is_user ? upper[0] : upper[1];
    len_spread = ADDR_W'(upper[LEN_LSB +: LEN_W]) << BASE_LSB;
    cmp_mask   = BASE_MASK & ~len_spread;
    match      = usable && ((ea & cmp_mask) == (upper & BASE_MASK));
    page       = ((lower & cmp_mask) | (ea & ~cmp_mask)) & PAGE_MASK;
    perm       = decode_prot(lower[1:0]);
  end

endmodule

// File: rtl/blk_prio_sel.sv
module blk_prio_sel #(
  parameter int N = 4,
  parameter int W = 35
) (
  input  logic [N-1:0]        req,
  input  logic [N-1:0][W-1:0] data,
  output logic                any,
  output logic [W-1:0]        sel
);

  logic [N-1:0] grant;

  always_comb begin
    logic taken;
    taken = 1'b0;
    sel   = '0;
    for (int i = 0; i < N; i++) begin
      grant[i] = req[i] && !taken;
      taken    = taken | req[i];
      if (grant[i]) sel = data[i];
    end
    any = taken;
  end

  // R5: at most one winner, and only among requesters
  always_comb begin
    assert_grant_onehot_R5: assert ($onehot0(grant));
    assert_grant_subset_R5: assert ((grant & ~req) == '0);
  end

endmodule

// File: rtl/blk_xlate_match.sv
module blk_xlate_match
  import blk_xlate_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int N_ENT     = 4,
  parameter int BASE_LSB  = 17,
  parameter int LEN_LSB   = 2,
  parameter int LEN_W     = 11,
  parameter int PAGE_BITS = 12,
  localparam int IDX_W    = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_fetch_side,
  input  logic              wr_lower,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] lk_ea,
  input  logic              lk_fetch,
  input  logic              lk_user,
  output logic              hit,
  output logic [ADDR_W-1:0] real_page,
  output logic              can_read,
  output logic              can_write,
  output logic              can_exec
);

  localparam int SEL_W = ADDR_W + 3;

  logic [ADDR_W-1:0] up_q [2][N_ENT];
  logic [ADDR_W-1:0] lo_q [2][N_ENT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < 2; s++)
        for (int i = 0; i < N_ENT; i++) begin
          up_q[s][i] <= '0;
          lo_q[s][i] <= '0;
        end
    end else if (wr_en && (int'(wr_idx) < N_ENT)) begin
      if (wr_lower) lo_q[wr_fetch_side][wr_idx] <= wr_data;
      else          up_q[wr_fetch_side][wr_idx] <= wr_data;
    end
  end

  logic [N_ENT-1:0]            ent_hit;
  logic [N_ENT-1:0][SEL_W-1:0] ent_res;

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    logic [ADDR_W-1:0] up_s, lo_s, pg;
    blk_perm_t         pm;

    assign up_s = lk_fetch ? up_q[1][g] : up_q[0][g];
    assign lo_s = lk_fetch ? lo_q[1][g] : lo_q[0][g];

    blk_entry_cmp #(
      .ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB), .LEN_LSB(LEN_LSB),
      .LEN_W(LEN_W), .PAGE_BITS(PAGE_BITS)
    ) i_cmp (
      .upper(up_s), .lower(lo_s), .ea(lk_ea), .is_user(lk_user),
      .match(ent_hit[g]), .page(pg), .perm(pm)
    );

    assign ent_res[g] = {pg, pm};
  end

  logic             any_hit;
  logic [SEL_W-1:0] win;

  blk_prio_sel #(.N(N_ENT), .W(SEL_W)) i_sel (
    .req(ent_hit), .data(ent_res), .any(any_hit), .sel(win)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hit       <= 1'b0;
      real_page <= '0;
      can_read  <= 1'b0;
      can_write <= 1'b0;
      can_exec  <= 1'b0;
    end else begin
      hit       <= any_hit;
      real_page <= win[SEL_W-1:3];
      can_read  <= win[2];
      can_write <= win[1];
      can_exec  <= win[0];
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!hit && real_page == '0 && !can_read && !can_write && !can_exec));

  assert_miss_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (real_page == '0 && !can_read && !can_write && !can_exec));

  assert_page_align_R4: assert property (@(posedge clk) disable iff (rst)
    real_page[PAGE_BITS-1:0] == '0);

  assert_write_rights_R6: assert property (@(posedge clk) disable iff (rst)
    can_write |-> (can_read && can_exec));

  assert_read_exec_pair_R6: assert property (@(posedge clk) disable iff (rst)
    can_read == can_exec);

endmodule

// File: tb/test_blk_xlate_match.sv
module test_blk_xlate_match;

  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_fetch_side = 1'b0, wr_lower = 1'b0;
  logic [1:0]  wr_idx = '0;
  logic [31:0] wr_data = '0, lk_ea = '0;
  logic        lk_fetch = 1'b0, lk_user = 1'b0;
  logic        hit, can_read, can_write, can_exec;
  logic [31:0] real_page;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [31:0] sh_up [2][N];
  logic [31:0] sh_lo [2][N];

  always #4 clk = ~clk;

  blk_xlate_match i_blk_xlate_match (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_fetch_side(wr_fetch_side),
    .wr_lower(wr_lower), .wr_idx(wr_idx), .wr_data(wr_data),
    .lk_ea(lk_ea), .lk_fetch(lk_fetch), .lk_user(lk_user),
    .hit(hit), .real_page(real_page), .can_read(can_read),
    .can_write(can_write), .can_exec(can_exec)
  );

  function automatic logic [31:0] mk_up(input logic [31:0] base, input logic [10:0] len,
                                        input logic sv, input logic uv);
    return (base & 32'hFFFE0000) | (32'(len) << 2) | (32'(sv) << 1) | 32'(uv);
  endfunction

  // Expected result from the requirements: {hit, page, r, w, x}
  function automatic logic [35:0] expect_of(input logic side, input logic [31:0] ea,
                                            input logic user);
    for (int i = 0; i < N; i++) begin
      logic [31:0] u, l, m;
      logic ok;
      u  = sh_up[side][i];
      l  = sh_lo[side][i];
      ok = user ? u[0] : u[1];
      m  = 32'hFFFE0000 & ~((u & 32'h00001FFC) << 15);
      if (ok && ((ea & m) == (u & 32'hFFFE0000))) begin
        logic [2:0] rwx;
        case (l[1:0])
          2'd0: rwx = 3'b000;
          2'd2: rwx = 3'b111;
          default: rwx = 3'b101;
        endcase
        return {1'b1, ((l & m) | (ea & ~m)) & 32'hFFFFF000, rwx};
      end
    end
    return '0;
  endfunction

  function automatic logic [35:0] outs();
    return {hit, real_page, can_read, can_write, can_exec};
  endfunction

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_word(input logic side, input logic lower, input int idx,
                            input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_fetch_side = side; wr_lower = lower; wr_idx = 2'(idx); wr_data = d;
    if (lower) sh_lo[side][idx] = d; else sh_up[side][idx] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input string req, input logic side, input logic [31:0] ea,
                      input logic user);
    @(negedge clk);
    lk_ea = ea; lk_fetch = side; lk_user = user;
    @(negedge clk);
    check(req, outs(), expect_of(side, ea, user));
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < N; i++) begin sh_up[s][i] = '0; sh_lo[s][i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 outputs after reset", outs(), '0);
    look("R1 data bank empty", 1'b0, 32'h0000_0000, 1'b0);
    look("R1 fetch bank empty", 1'b1, 32'h1234_5678, 1'b1);
    look("R1 empty user", 1'b0, 32'h0000_0000, 1'b1);

    // R2: privilege valid bits
    write_word(1'b0, 1'b0, 0, mk_up(32'h1000_0000, 11'd0, 1'b1, 1'b0));
    write_word(1'b0, 1'b1, 0, 32'h8000_0002);
    look("R2 supervisor-only entry, user miss", 1'b0, 32'h1001_2345, 1'b1);
    look("R2 supervisor-only entry, supervisor hit", 1'b0, 32'h1001_2345, 1'b0);
    check("R4 literal page", {28'h0, real_page[31:28]}, 36'h8);
    write_word(1'b0, 1'b0, 0, mk_up(32'h1000_0000, 11'd0, 1'b0, 1'b1));
    look("R2 user-only entry, supervisor miss", 1'b0, 32'h1001_2345, 1'b0);
    look("R2 user-only entry, user hit", 1'b0, 32'h1001_2345, 1'b1);
    look("R3 outside smallest block", 1'b0, 32'h1002_0000, 1'b1);

    // R6: protection codes
    for (int c = 0; c < 4; c++) begin
      write_word(1'b0, 1'b1, 0, 32'h8000_0000 | 32'(c));
      look("R6 protection code", 1'b0, 32'h1000_0ABC, 1'b1);
    end

    // R5: overlap, lowest index wins
    write_word(1'b0, 1'b0, 1, mk_up(32'h2000_0000, 11'h00F, 1'b1, 1'b1));
    write_word(1'b0, 1'b1, 1, 32'h4000_0001);
    write_word(1'b0, 1'b0, 2, mk_up(32'h2000_0000, 11'h7FF, 1'b1, 1'b1));
    write_word(1'b0, 1'b1, 2, 32'h5000_0002);
    look("R5 entry 1 over entry 2", 1'b0, 32'h2001_F123, 1'b0);
    check("R5 winner rights read-exec only", {33'h0, can_read, can_write, can_exec}, 36'h5);
    look("R5 entry 2 alone beyond entry 1", 1'b0, 32'h2345_6789, 1'b0);
    write_word(1'b0, 1'b0, 1, mk_up(32'h2000_0000, 11'h00F, 1'b0, 1'b1));
    look("R5 entry 1 invalid for supervisor, entry 2 wins", 1'b0, 32'h2001_F123, 1'b0);
    check("R5 entry 2 write right", {35'h0, can_write}, 36'h1);
    look("R5 entry 1 still wins for user", 1'b0, 32'h2001_F123, 1'b1);

    // R7: bank selection
    write_word(1'b1, 1'b0, 0, mk_up(32'h1000_0000, 11'd0, 1'b1, 1'b1));
    write_word(1'b1, 1'b1, 0, 32'h9000_0003);
    look("R7 fetch uses instruction bank", 1'b1, 32'h1001_2345, 1'b0);
    check("R7 fetch page", {4'h0, real_page}, 36'h0_9001_2000);
    look("R7 data bank unaffected", 1'b0, 32'h1001_2345, 1'b0);
    look("R7 fetch misses on data-only block", 1'b1, 32'h2001_F123, 1'b0);

    // R3 / R4: large block and base with masked-out ones
    write_word(1'b0, 1'b0, 3, mk_up(32'h3000_0000, 11'h7FF, 1'b1, 1'b1));
    write_word(1'b0, 1'b1, 3, 32'h6000_0002);
    look("R3 R4 256MB block", 1'b0, 32'h3ABC_DEF0, 1'b0);
    check("R4 page composition", {4'h0, real_page}, 36'h0_6ABC_D000);
    write_word(1'b0, 1'b0, 3, mk_up(32'h3002_0000, 11'h007, 1'b1, 1'b1));
    look("R3 base with masked-out ones never hits", 1'b0, 32'h3002_0000, 1'b0);
    look("R8 miss zero outputs", 1'b0, 32'hF000_0000, 1'b1);
    check("R8 literal zero", outs(), '0);

    // R9: latency of exactly one edge
    @(negedge clk);
    lk_ea = 32'h1000_0ABC; lk_fetch = 1'b1; lk_user = 1'b0;
    #1 check("R9 output held before edge", outs(), '0);
    @(negedge clk);
    check("R9 output after one edge", outs(), expect_of(1'b1, 32'h1000_0ABC, 1'b0));

    // Sweep: reprogram both banks, then many lookups
    begin
      logic [31:0] lf;
      logic [10:0] lens [4];
      lens[0] = 11'h000; lens[1] = 11'h001; lens[2] = 11'h07F; lens[3] = 11'h7FF;
      lf = 32'hACE1_2345;
      for (int s = 0; s < 2; s++)
        for (int i = 0; i < N; i++) begin
          lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
          write_word(1'(s), 1'b0, i,
                     mk_up({lf[31:28], 28'h0} | (lf & 32'h000E_0000), lens[(i + s) % 4],
                           lf[5] | lf[6], lf[7] | lf[8]));
          write_word(1'(s), 1'b1, i, {lf[15:0], lf[31:16]});
        end
      for (int k = 0; k < 3000; k++) begin
        logic [31:0] ea;
        logic side;
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        side = lf[3];
        ea = (k % 3 == 0) ? lf : ((sh_up[side][k % N] & 32'hFFFE0000) ^ (lf & 32'h0FFF_FFFF));
        look("R3 R4 R5 R6 R7 R8 sweep", side, ea, lf[9]);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule